// File: doc/BRIEF.md
# Floating-Point Rounding-Control Shadow

This block stands in for two floating-point control registers: a 16-bit legacy stack-unit control word and a 32-bit vector-unit control/status word. The only state it keeps is the 2-bit rounding mode of each register. On a load it takes the rounding field and drops every other bit. If the loaded word asks for something the datapath cannot honour, it raises a one-cycle warning with a reason code. The datapath reads the two rounding modes directly from output pins.

On a store, the block does not return the word that was loaded. It builds a fixed default word for the selected register, puts the current rounding mode into it, and returns that word on a valid/ready response channel. Loads arrive on a valid/ready channel whose ready is always high, so a load is accepted in any cycle in which it is valid. Store requests are refused while a response is waiting and its ready is low. A waiting response keeps its value until it is taken.

Top module: `cws_shadow`

## Requirements
- R1: After reset, both rounding modes read 0 (nearest), and `st_valid` and `warn_valid` are low. `ld_ready` stays high at all times.
- R2: An accepted load with `ld_sel`=0 sets `x87_rmode` to `ld_word[11:10]` at the next clock edge. Bits 31:16 and every other bit of the word have no effect on the mode, and `sse_rmode` is unchanged.
- R3: An accepted load with `ld_sel`=1 sets `sse_rmode` to `ld_word[14:13]` at the next clock edge, and `x87_rmode` is unchanged. Mode encoding: 0 nearest, 1 down, 2 up, 3 toward zero.
- R4: A store of the legacy word (`st_req_sel`=0) returns 0x037F with the rounding mode in bits 11:10, zero-extended, with `st_src`=0.
- R5: A store of the vector word (`st_req_sel`=1) returns 0x1F80 with the rounding mode in bits 14:13, with `st_src`=1.
- R6: A legacy load warns with code 1 if any of bits 5:0 is 0 (an exception is unmasked). Otherwise it warns with code 2 if bits 9:8 are not binary 11 (precision is not 80-bit). Otherwise it does not warn.
- R7: A vector load warns with code 1 if any of bits 12:7 is 0. Otherwise it warns with code 2 if bit 15 (flush-to-zero) is set. Otherwise it warns with code 3 if bit 6 (denormals-are-zero) is set. Otherwise it does not warn.
- R8: `warn_valid` is high for exactly the one cycle after a warning load, with `warn_src` equal to that load's `ld_sel`. The rounding mode is still updated by a load that warns.
- R9: A response is returned one cycle after its store request is accepted. While `st_valid` is high and `st_ready` is low, `st_word` and `st_src` hold steady and `st_req_ready` is low.
- R10: If a load and a store of the same register are accepted in the same cycle, the store returns the mode that was in place before the load.
- R11: Loads in consecutive cycles are each accepted and each decoded on its own: every load produces its own warning, and the last load sets the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load word is present |
| ld_ready | output | 1 | Load can be accepted (always high) |
| ld_sel | input | 1 | Load target: 0 legacy word, 1 vector word |
| ld_word | input | WORD_W | Word to load |
| st_req_valid | input | 1 | Store request |
| st_req_ready | output | 1 | Store request can be accepted |
| st_req_sel | input | 1 | Store source: 0 legacy word, 1 vector word |
| st_valid | output | 1 | Store response is present |
| st_ready | input | 1 | Consumer takes the response |
| st_word | output | WORD_W | Synthesised stored word |
| st_src | output | 1 | Register the response came from |
| warn_valid | output | 1 | One-cycle warning strobe |
| warn_src | output | 1 | Register whose load warned |
| warn_code | output | 2 | 1 unmasked exception, 2 precision/flush-to-zero, 3 denormals-are-zero |
| x87_rmode | output | 2 | Legacy rounding mode |
| sse_rmode | output | 2 | Vector rounding mode |

## Verification
The bench builds the block with its default word width of 32. At that width, legacy loads with bits 31:16 set can be driven, and so can vector loads with upper bits set, which shows that those bits change neither the mode nor the warning. The default width also exposes every warning field position, including flush-to-zero at bit 15. The tests drive words that set several warning conditions at once so that the priority order is checked. They hold a response back while a load is accepted, and they issue a load and a store of the same register in the same cycle.

// File: rtl/cws_pkg.sv
package cws_pkg;

  localparam int RM_W      = 2;
  localparam int MASK_W    = 6;

  // legacy word layout
  localparam int LEG_RC_LSB   = 10;
  localparam int LEG_PC_LSB   = 8;
  localparam int LEG_MASK_LSB = 0;
  localparam int LEG_W        = 16;
  localparam logic [LEG_W-1:0] LEG_BASE = 16'h037F;

  // vector word layout
  localparam int SSE_RC_LSB   = 13;
  localparam int SSE_MASK_LSB = 7;
  localparam int SSE_FTZ_BIT  = 15;
  localparam int SSE_DAZ_BIT  = 6;
  localparam int SSE_W        = 16;
  localparam logic [SSE_W-1:0] SSE_BASE = 16'h1F80;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'd0,
    RM_DOWN    = 2'd1,
    RM_UP      = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    WARN_NONE     = 2'd0,
    WARN_UNMASK   = 2'd1,
    WARN_PREC_FTZ = 2'd2,
    WARN_DAZ      = 2'd3
  } warn_e;

  function automatic logic [LEG_W-1:0] fmt_legacy(input logic [RM_W-1:0] rm);
    logic [LEG_W-1:0] w;
    w = LEG_BASE;
    w[LEG_RC_LSB +: RM_W] = rm;
    return w;
  endfunction

  function automatic logic [SSE_W-1:0] fmt_sse(input logic [RM_W-1:0] rm);
    logic [SSE_W-1:0] w;
    w = SSE_BASE;
    w[SSE_RC_LSB +: RM_W] = rm;
    return w;
  endfunction

endpackage

// File: rtl/cws_decode.sv
module cws_decode
  import cws_pkg::*;
#(
  parameter bit IS_SSE = 1'b0,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic [RM_W-1:0]   rmode,
  output warn_e             code
);

  logic unused_bits;
  assign unused_bits = ^word;

  generate
    if (IS_SSE) begin : g_sse
      logic any_unmasked;
      assign any_unmasked = ~&word[SSE_MASK_LSB +: MASK_W];
      assign rmode        = word[SSE_RC_LSB +: RM_W];
      always_comb begin
        if (any_unmasked)          code = WARN_UNMASK;
        else if (word[SSE_FTZ_BIT]) code = WARN_PREC_FTZ;
        else if (word[SSE_DAZ_BIT]) code = WARN_DAZ;
        else                        code = WARN_NONE;
      end
    end else begin : g_leg
      logic any_unmasked;
      logic non_ext_prec;
      assign any_unmasked = ~&word[LEG_MASK_LSB +: MASK_W];
      assign non_ext_prec = ~&word[LEG_PC_LSB +: 2];
      assign rmode        = word[LEG_RC_LSB +: RM_W];
      always_comb begin
        if (any_unmasked)      code = WARN_UNMASK;
        else if (non_ext_prec) code = WARN_PREC_FTZ;
        else                   code = WARN_NONE;
      end
    end
  endgenerate

endmodule

// File: rtl/cws_mode_reg.sv
module cws_mode_reg
  import cws_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RM_W-1:0] d,
  output logic [RM_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RM_NEAREST;
    else if (we) q <= d;
  end

endmodule

// File: rtl/cws_store_port.sv
module cws_store_port
  import cws_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_sel,
  input  logic [RM_W-1:0]   leg_rm,
  input  logic [RM_W-1:0]   sse_rm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_src
);

  logic              take;
  logic [WORD_W-1:0] next_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    if (req_sel) next_word = WORD_W'(fmt_sse(sse_rm));
    else         next_word = WORD_W'(fmt_legacy(leg_rm));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
      rsp_src   <= 1'b0;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_word  <= next_word;
        rsp_src   <= req_sel;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cws_shadow.sv
module cws_shadow
  import cws_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              st_req_valid,
  output logic              st_req_ready,
  input  logic              st_req_sel,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_word,
  output logic              st_src,
  output logic              warn_valid,
  output logic              warn_src,
  output logic [1:0]        warn_code,
  output logic [RM_W-1:0]   x87_rmode,
  output logic [RM_W-1:0]   sse_rmode
);

  localparam int NREG = 2;

  logic [RM_W-1:0] dec_rm   [NREG];
  warn_e           dec_code [NREG];
  logic [RM_W-1:0] cur_rm   [NREG];
  logic            ld_take;
  warn_e           sel_code;

  assign ld_ready = 1'b1;
  assign ld_take  = ld_valid && ld_ready;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      cws_decode #(.IS_SSE(i == 1), .WORD_W(WORD_W)) u_dec (
        .word  (ld_word),
        .rmode (dec_rm[i]),
        .code  (dec_code[i])
      );
      cws_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_take && (ld_sel == (i == 1))),
        .d     (dec_rm[i]),
        .q     (cur_rm[i])
      );
    end
  endgenerate

  assign x87_rmode = cur_rm[0];
  assign sse_rmode = cur_rm[1];

  assign sel_code = ld_sel ? dec_code[1] : dec_code[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_valid <= 1'b0;
      warn_src   <= 1'b0;
      warn_code  <= WARN_NONE;
    end else begin
      warn_valid <= ld_take && (sel_code != WARN_NONE);
      if (ld_take) begin
        warn_src  <= ld_sel;
        warn_code <= sel_code;
      end
    end
  end

  cws_store_port #(.WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (st_req_valid),
    .req_ready (st_req_ready),
    .req_sel   (st_req_sel),
    .leg_rm    (cur_rm[0]),
    .sse_rm    (cur_rm[1]),
    .rsp_valid (st_valid),
    .rsp_ready (st_ready),
    .rsp_word  (st_word),
    .rsp_src   (st_src)
  );

endmodule

// File: rtl/cws_chk.sv
module cws_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_sel,
  input logic [WORD_W-1:0] ld_word,
  input logic              st_req_ready,
  input logic              st_valid,
  input logic              st_ready,
  input logic [WORD_W-1:0] st_word,
  input logic              st_src,
  input logic              warn_valid,
  input logic [1:0]        warn_code,
  input logic              warn_src,
  input logic [1:0]        x87_rmode,
  input logic [1:0]        sse_rmode
);

  localparam logic [WORD_W-1:0] LEG_KEEP = ~WORD_W'(16'h0C00);
  localparam logic [WORD_W-1:0] SSE_KEEP = ~WORD_W'(16'h6000);

  AST_LEG_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_sel) |=> (x87_rmode == $past(ld_word[11:10]))); // R2
  AST_LEG_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && !ld_sel) |=> $stable(x87_rmode)); // R2
  AST_SSE_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel) |=> (sse_rmode == $past(ld_word[14:13]))); // R3
  AST_SSE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && ld_sel) |=> $stable(sse_rmode)); // R3
  AST_LEG_STORE_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_src) |-> ((st_word & LEG_KEEP) == WORD_W'(16'h037F))); // R4
  AST_SSE_STORE_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_src) |-> ((st_word & SSE_KEEP) == WORD_W'(16'h1F80))); // R5
  AST_LEG_UNMASK_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_sel && (ld_word[5:0] != 6'h3F)) |=> (warn_valid && warn_code == 2'd1 && !warn_src)); // R6
  AST_SSE_FTZ_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sel && (ld_word[12:7] == 6'h3F) && ld_word[15]) |=> (warn_valid && warn_code == 2'd2 && warn_src)); // R7
  AST_WARN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    warn_valid |-> ($past(ld_valid) && warn_code != 2'd0)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_word) && $stable(st_src))); // R9
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> !st_req_ready); // R9

endmodule

bind cws_shadow cws_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_valid     (ld_valid),
  .ld_sel       (ld_sel),
  .ld_word      (ld_word),
  .st_req_ready (st_req_ready),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .st_word      (st_word),
  .st_src       (st_src),
  .warn_valid   (warn_valid),
  .warn_code    (warn_code),
  .warn_src     (warn_src),
  .x87_rmode    (x87_rmode),
  .sse_rmode    (sse_rmode)
);

// File: tb/sim_cws_shadow.sv
module sim_cws_shadow;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_sel = 1'b0;
  logic [31:0] ld_word = '0;
  logic        st_req_valid = 1'b0;
  logic        st_req_ready;
  logic        st_req_sel = 1'b0;
  logic        st_valid;
  logic        st_ready = 1'b1;
  logic [31:0] st_word;
  logic        st_src;
  logic        warn_valid;
  logic        warn_src;
  logic [1:0]  warn_code;
  logic [1:0]  x87_rmode;
  logic [1:0]  sse_rmode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cws_shadow #(.WORD_W(32)) u0 (.*);

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input bit sel, input logic [31:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_word = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic store(input bit sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    st_req_valid = 1'b1; st_req_sel = sel; st_ready = 1'b1;
    @(negedge clk);
    st_req_valid = 1'b0;
    eq({req, " st_valid"}, 32'(st_valid), 32'd1);
    eq({req, " st_word"}, st_word, exp);
    eq({req, " st_src"}, 32'(st_src), 32'(sel));
  endtask

  task automatic t_reset;
    @(negedge clk);
    eq("R1 x87_rmode", 32'(x87_rmode), 32'd0);
    eq("R1 sse_rmode", 32'(sse_rmode), 32'd0);
    eq("R1 st_valid", 32'(st_valid), 32'd0);
    eq("R1 warn_valid", 32'(warn_valid), 32'd0);
    eq("R1 ld_ready", 32'(ld_ready), 32'd1);
  endtask

  task automatic t_legacy_modes;
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w;
      w = 32'h037F | (32'(m) << 10);
      if (m == 3) w = w | 32'hA5A5_0000;
      load(1'b0, w);
      eq("R2 x87_rmode", 32'(x87_rmode), 32'(m));
      eq("R2 sse untouched", 32'(sse_rmode), 32'd0);
      eq("R2 no warn", 32'(warn_valid), 32'd0);
      store(1'b0, 32'h037F | (32'(m) << 10), "R4");
    end
  endtask

  task automatic t_sse_modes;
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w;
      w = 32'h1F80 | (32'(m) << 13);
      if (m == 1) w = w | 32'hABCD_0000;
      load(1'b1, w);
      eq("R3 sse_rmode", 32'(sse_rmode), 32'(m));
      eq("R3 x87 untouched", 32'(x87_rmode), 32'd3);
      eq("R3 no warn", 32'(warn_valid), 32'd0);
      store(1'b1, 32'h1F80 | (32'(m) << 13), "R5");
    end
  endtask

  task automatic t_legacy_warn;
    logic [15:0] w [4] = '{16'h0B7E, 16'h027E, 16'h087F, 16'h0F3F};
    logic [1:0]  c [4] = '{2'd1, 2'd1, 2'd2, 2'd0};
    logic [1:0]  m [4] = '{2'd2, 2'd0, 2'd2, 2'd3};
    for (int i = 0; i < 4; i++) begin
      load(1'b0, 32'(w[i]));
      eq("R6 warn_valid", 32'(warn_valid), 32'(c[i] != 2'd0));
      if (c[i] != 2'd0) begin
        eq("R6 warn_code", 32'(warn_code), 32'(c[i]));
        eq("R8 warn_src", 32'(warn_src), 32'd0);
      end
      eq("R8 mode updated", 32'(x87_rmode), 32'(m[i]));
      @(negedge clk);
      eq("R8 pulse width", 32'(warn_valid), 32'd0);
    end
  endtask

  task automatic t_sse_warn;
    logic [15:0] w [5] = '{16'h9F80, 16'h7FC0, 16'hDF40, 16'h9FC0, 16'h3F00};
    logic [1:0]  c [5] = '{2'd2, 2'd3, 2'd1, 2'd2, 2'd1};
    logic [1:0]  m [5] = '{2'd0, 2'd3, 2'd2, 2'd0, 2'd1};
    for (int i = 0; i < 5; i++) begin
      load(1'b1, 32'(w[i]));
      eq("R7 warn_valid", 32'(warn_valid), 32'd1);
      eq("R7 warn_code", 32'(warn_code), 32'(c[i]));
      eq("R8 warn_src", 32'(warn_src), 32'd1);
      eq("R8 mode updated", 32'(sse_rmode), 32'(m[i]));
    end
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    st_req_valid = 1'b1; st_req_sel = 1'b1; st_ready = 1'b0;
    @(negedge clk);
    st_req_valid = 1'b0;
    eq("R9 st_valid", 32'(st_valid), 32'd1);
    eq("R9 st_word", st_word, 32'h3F80);
    eq("R9 req_ready low", 32'(st_req_ready), 32'd0);
    ld_valid = 1'b1; ld_sel = 1'b1; ld_word = 32'h7F80;
    @(negedge clk);
    ld_valid = 1'b0;
    eq("R9 word held", st_word, 32'h3F80);
    eq("R9 valid held", 32'(st_valid), 32'd1);
    eq("R3 mode during hold", 32'(sse_rmode), 32'd3);
    st_ready = 1'b1;
    @(negedge clk);
    eq("R9 drained", 32'(st_valid), 32'd0);
    eq("R9 req_ready back", 32'(st_req_ready), 32'd1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 1'b0; ld_word = 32'h037F;
    st_req_valid = 1'b1; st_req_sel = 1'b0; st_ready = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; st_req_valid = 1'b0;
    eq("R10 old mode stored", st_word, 32'h0F7F);
    eq("R10 new mode", 32'(x87_rmode), 32'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 1'b0; ld_word = 32'h077E;
    @(negedge clk);
    eq("R11 first warn", 32'(warn_valid), 32'd1);
    eq("R11 first code", 32'(warn_code), 32'd1);
    eq("R11 first mode", 32'(x87_rmode), 32'd1);
    ld_word = 32'h0B7F;
    @(negedge clk);
    ld_valid = 1'b0;
    eq("R11 second no warn", 32'(warn_valid), 32'd0);
    eq("R11 second mode", 32'(x87_rmode), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_legacy_modes();
    t_sse_modes();
    t_legacy_warn();
    t_sse_warn();
    t_backpressure();
    t_same_cycle();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule